// File: doc/BRIEF.md
# CTCSS Period Tone Detector

This block decides whether a squared-up sub-audio signal carries the one CTCSS tone selected by a 6-bit code. The analog front end band-pass filters and hard-limits the received sub-audio band. This block sees only the resulting 1-bit stream. It times each full cycle of that stream in reference-clock counts and compares the result against a window around the target period of the selected tone. It then feeds each hit or miss into a saturating up/down integrator that has two switching thresholds.

The integrator output is the tone-detect flag. The block also provides an active-low copy of that flag. A third output opens the received voice path when the tone is present, when the listen override is held, or when the no-tone code is programmed. In transmit mode the detector is cleared and the voice path stays closed.

All period constants assume a 1 MHz reference. The parameter `SCALE_SHR` divides every period constant by 2^SCALE_SHR, for use with a slower reference clock.

Top module: `ctcss_tone_detector`

## Requirements
- R1: A period is the number of clock cycles between two successive rising edges of `tone_in`. The first rising edge after reset, or after a timeout, only arms the measurement and yields no hit or miss.
- R2: For target period T, the tolerance is tol = floor(T/64) + floor(T/256). A period P is a hit when T - tol <= P <= T + tol, and a miss otherwise.
- R3: The integrator count rises by one on each hit and falls by one on each miss. It is clamped to the range 0 to `INTEG_MAX` and is zero after reset.
- R4: `tone_detect` goes high when the count reaches HI = floor(2*INTEG_MAX/3). It goes low when the count falls to LO = floor(INTEG_MAX/3) or below, and it holds its value between the two thresholds. With the defaults (HI = 16), a steady tone is declared within 16 measured periods, which is under 240 ms at 67 Hz.
- R5: When no rising edge arrives for TIMEOUT = floor(15300 / 2^SCALE_SHR) cycles, one miss is counted and the measurement disarms. This repeats for as long as the input stays idle.
- R6: `decode_n` is always the inverse of `tone_detect`.
- R7: `rx_audio_en` is 1 when `rx_mode` is 1 and at least one of these holds: `tone_detect` is 1, `listen_override` is 1, or the code is the no-tone code.
- R8: While `rx_mode` is 0, `tone_detect` and `rx_audio_en` are 0. On the next clock edge the integrator is cleared to zero, so a return to receive starts undetected.
- R9: Code 63 is the no-tone code. Codes 39 to 62 are unused. Neither the no-tone code nor an unused code ever produces a hit.
- R10: Codes 0 to 38 select the standard tones in ascending frequency, with T = floor(round(1e6/f) / 2^SCALE_SHR). Examples: code 0 is 67.0 Hz (14925 counts), code 12 is 100.0 Hz (10000 counts), and code 38 is 250.3 Hz (3995 counts).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (1 MHz when SCALE_SHR = 0) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_in | input | 1 | Limited sub-audio signal, asynchronous |
| tone_code | input | 6 | Selected tone code |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| listen_override | input | 1 | Opens the receive voice path regardless of the decode result |
| tone_detect | output | 1 | High while the selected tone is decoded |
| decode_n | output | 1 | Active-low decode output |
| rx_audio_en | output | 1 | Receive voice path enable |

## Verification
A rising edge on `tone_in` reaches the integrator, and therefore `tone_detect` and `decode_n`, five clock cycles later: two synchroniser stages, an edge stage, the window stage and the integrator register. `rx_audio_en` follows `rx_mode`, `listen_override` and the code combinationally, while the integrator clear in transmit takes one clock edge. A timeout miss appears about TIMEOUT cycles after the last edge. The bench drives whole periods and samples on a falling clock edge at least a full tone period after the last edge, which is far beyond the five-cycle latency. For the timeout checks it samples hundreds of cycles away from each expected timeout instant, so every sample falls in a settled interval.

// File: rtl/ctcss_det_pkg.sv
package ctcss_det_pkg;

    localparam int unsigned CODE_W       = 6;
    localparam logic [5:0]  NOTONE_CODE  = 6'd63;
    localparam int unsigned NUM_TONES    = 39;
    // longest legal period (67 Hz plus tolerance) rounded up, in 1 MHz counts
    localparam int unsigned BASE_TIMEOUT = 15300;

    // Target period in 1 MHz counts, ascending frequency; 0 = no target.
    function automatic int unsigned base_period(input logic [5:0] code);
        case (code)
            6'd0:  return 14925;  6'd1:  return 14430;  6'd2:  return 13908;
            6'd3:  return 13441;  6'd4:  return 12987;  6'd5:  return 12547;
            6'd6:  return 12121;  6'd7:  return 11710;  6'd8:  return 11299;
            6'd9:  return 10929;  6'd10: return 10549;  6'd11: return 10267;
            6'd12: return 10000;  6'd13: return 9662;   6'd14: return 9328;
            6'd15: return 9017;   6'd16: return 8711;   6'd17: return 8418;
            6'd18: return 8130;   6'd19: return 7855;   6'd20: return 7587;
            6'd21: return 7326;   6'd22: return 7077;   6'd23: return 6840;
            6'd24: return 6605;   6'd25: return 6382;   6'd26: return 6165;
            6'd27: return 5956;   6'd28: return 5754;   6'd29: return 5559;
            6'd30: return 5371;   6'd31: return 5187;   6'd32: return 4914;
            6'd33: return 4746;   6'd34: return 4585;   6'd35: return 4431;
            6'd36: return 4281;   6'd37: return 4136;   6'd38: return 3995;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/ctcss_period_meter.sv
module ctcss_period_meter
    import ctcss_det_pkg::*;
#(
    parameter int unsigned SHR = 0
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              tone_in,
    output logic                                              ev_valid,
    output logic                                              ev_timeout,
    output logic [$clog2((BASE_TIMEOUT >> SHR) + 1)-1:0]      ev_period
);

    localparam int unsigned TIMEOUT = BASE_TIMEOUT >> SHR;
    localparam int unsigned CW      = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic          sync3;
        logic          armed;
        logic [CW-1:0] cnt;
        logic          ev_valid;
        logic          ev_timeout;
        logic [CW-1:0] ev_period;
    } meter_t;

    meter_t st_d, st_q;
    logic   rise;

    always_comb begin
        st_d            = st_q;
        st_d.sync1      = tone_in;
        st_d.sync2      = st_q.sync1;
        st_d.sync3      = st_q.sync2;
        st_d.ev_valid   = 1'b0;
        st_d.ev_timeout = 1'b0;
        rise            = st_q.sync2 & ~st_q.sync3;
        if (rise) begin
            if (st_q.armed) begin
                st_d.ev_valid  = 1'b1;
                st_d.ev_period = st_q.cnt;
            end
            st_d.armed = 1'b1;
            st_d.cnt   = CW'(1);
        end else if (st_q.cnt >= CW'(TIMEOUT)) begin
            st_d.ev_valid   = 1'b1;
            st_d.ev_timeout = 1'b1;
            st_d.ev_period  = st_q.cnt;
            st_d.armed      = 1'b0;
            st_d.cnt        = CW'(1);
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_valid   = st_q.ev_valid;
    assign ev_timeout = st_q.ev_timeout;
    assign ev_period  = st_q.ev_period;

    // An edge seen while disarmed must not yield a measurement.
    assert_arm_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !st_q.armed) |=> !st_q.ev_valid);

    // The running count never passes the timeout limit.
    assert_cnt_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(TIMEOUT));

endmodule

// File: rtl/ctcss_window_match.sv
module ctcss_window_match
    import ctcss_det_pkg::*;
#(
    parameter int unsigned SHR = 0
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [5:0]                                    tone_code,
    input  logic                                          ev_valid,
    input  logic                                          ev_timeout,
    input  logic [$clog2((BASE_TIMEOUT >> SHR) + 1)-1:0]  ev_period,
    output logic                                          dv_valid,
    output logic                                          dv_hit
);

    typedef struct packed {
        logic valid;
        logic hit;
    } verdict_t;

    verdict_t    vd_d, vd_q;
    int unsigned tgt, tol, lo_b, hi_b, per;

    always_comb begin
        tgt  = base_period(tone_code) >> SHR;
        tol  = (tgt >> 6) + (tgt >> 8);
        lo_b = tgt - tol;
        hi_b = tgt + tol;
        per  = 32'(ev_period);
        vd_d.valid = ev_valid;
        vd_d.hit   = ev_valid && !ev_timeout && (tgt != 0) &&
                     (per >= lo_b) && (per <= hi_b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vd_q <= '0;
        else        vd_q <= vd_d;
    end

    assign dv_valid = vd_q.valid;
    assign dv_hit   = vd_q.hit;

    assert_timeout_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_timeout) |=> (dv_valid && !dv_hit));

    assert_notone_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && tone_code == NOTONE_CODE) |=> !dv_hit);

endmodule

// File: rtl/ctcss_hyst_integrator.sv
module ctcss_hyst_integrator #(
    parameter int unsigned MAX = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dv_valid,
    input  logic dv_hit,
    output logic detect
);

    localparam int unsigned HI = (2 * MAX) / 3;
    localparam int unsigned LO = MAX / 3;
    localparam int unsigned AW = $clog2(MAX + 1);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic          det;
    } integ_t;

    integ_t ig_d, ig_q;

    always_comb begin
        ig_d = ig_q;
        if (!enable) begin
            ig_d.cnt = '0;
            ig_d.det = 1'b0;
        end else begin
            if (dv_valid) begin
                if (dv_hit && ig_q.cnt < AW'(MAX))
                    ig_d.cnt = ig_q.cnt + AW'(1);
                else if (!dv_hit && ig_q.cnt != '0)
                    ig_d.cnt = ig_q.cnt - AW'(1);
            end
            if (ig_d.cnt >= AW'(HI))      ig_d.det = 1'b1;
            else if (ig_d.cnt <= AW'(LO)) ig_d.det = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ig_q <= '0;
        else        ig_q <= ig_d;
    end

    assign detect = ig_q.det;

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ig_q.cnt <= AW'(MAX));

    assert_count_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dv_valid && enable) |=> $stable(ig_q.cnt));

    assert_detect_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ig_q.det) |-> ig_q.cnt >= AW'(HI));

    assert_detect_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ig_q.det) |-> ig_q.cnt <= AW'(LO));

endmodule

// File: rtl/ctcss_tone_detector.sv
module ctcss_tone_detector
    import ctcss_det_pkg::*;
#(
    parameter int unsigned SCALE_SHR = 0,
    parameter int unsigned INTEG_MAX = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_in,
    input  logic [5:0] tone_code,
    input  logic       rx_mode,
    input  logic       listen_override,
    output logic       tone_detect,
    output logic       decode_n,
    output logic       rx_audio_en
);

    localparam int unsigned CW = $clog2((BASE_TIMEOUT >> SCALE_SHR) + 1);

    logic          ev_valid, ev_timeout;
    logic [CW-1:0] ev_period;
    logic          dv_valid, dv_hit;
    logic          det_w;
    logic          notone;

    ctcss_period_meter #(.SHR(SCALE_SHR)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tone_in    (tone_in),
        .ev_valid   (ev_valid),
        .ev_timeout (ev_timeout),
        .ev_period  (ev_period)
    );

    ctcss_window_match #(.SHR(SCALE_SHR)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .tone_code  (tone_code),
        .ev_valid   (ev_valid),
        .ev_timeout (ev_timeout),
        .ev_period  (ev_period),
        .dv_valid   (dv_valid),
        .dv_hit     (dv_hit)
    );

    ctcss_hyst_integrator #(.MAX(INTEG_MAX)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (rx_mode),
        .dv_valid (dv_valid),
        .dv_hit   (dv_hit),
        .detect   (det_w)
    );

    always_comb begin
        notone      = (tone_code == NOTONE_CODE);
        tone_detect = det_w & rx_mode;
        decode_n    = ~tone_detect;
        rx_audio_en = rx_mode & (tone_detect | listen_override | notone);
    end

    // Transmit mode clears the integrator on the next edge.
    assert_tx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mode |=> !det_w);

endmodule

// File: tb/ctcss_tone_detector_tb.sv
module ctcss_tone_detector_tb_top;

    localparam int unsigned SHR  = 4;
    localparam int unsigned IMAX = 12;   // HI = 8, LO = 4

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_in = 1'b0;
    logic [5:0] tone_code = 6'd38;
    logic       rx_mode = 1'b1;
    logic       listen_override = 1'b0;
    logic       tone_detect, decode_n, rx_audio_en;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ctcss_tone_detector #(.SCALE_SHR(SHR), .INTEG_MAX(IMAX)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .tone_in         (tone_in),
        .tone_code       (tone_code),
        .rx_mode         (rx_mode),
        .listen_override (listen_override),
        .tone_detect     (tone_detect),
        .decode_n        (decode_n),
        .rx_audio_en     (rx_audio_en)
    );

    typedef struct packed {
        logic [5:0]  code;
        logic [11:0] per;
        logic [4:0]  edges;
        logic        rx;
        logic        ptl;
        logic        det;
        logic        aud;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{6'd38, 12'd249, 5'd9, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 lock on 8th hit
        '{6'd38, 12'd249, 5'd8, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 first edge arms only
        '{6'd38, 12'd252, 5'd9, 1'b1, 1'b0, 1'b1, 1'b1}, // R2 upper bound
        '{6'd38, 12'd254, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 above window
        '{6'd38, 12'd246, 5'd9, 1'b1, 1'b0, 1'b1, 1'b1}, // R2 lower bound
        '{6'd38, 12'd244, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 below window
        '{6'd12, 12'd625, 5'd9, 1'b1, 1'b0, 1'b1, 1'b1}, // R10 100 Hz
        '{6'd12, 12'd249, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0}, // R10 wrong tone
        '{6'd38, 12'd249, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 transmit
        '{6'd38, 12'd500, 5'd9, 1'b1, 1'b1, 1'b0, 1'b1}, // R7 listen override
        '{6'd63, 12'd249, 5'd9, 1'b1, 1'b0, 1'b0, 1'b1}, // R9 no-tone
        '{6'd63, 12'd249, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 no-tone in tx
        '{6'd0,  12'd932, 5'd9, 1'b1, 1'b0, 1'b1, 1'b1}, // R10 67 Hz
        '{6'd45, 12'd249, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0}, // R9 unused code
        '{6'd38, 12'd249, 5'd9, 1'b0, 1'b1, 1'b0, 1'b0}  // R8 override in tx
    };

    function automatic string vtag(input int i);
        case (i)
            1:       return "R1";
            2, 3, 4, 5: return "R2";
            6, 7, 12: return "R10";
            8, 11, 14: return "R8";
            9:       return "R7";
            10, 13:  return "R9";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        tone_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // n rising edges, each followed by p cycles (high for p/2)
    task automatic pulses(input int p, input int n);
        for (int k = 0; k < n; k++) begin
            tone_in = 1'b1;
            repeat (p / 2) @(negedge clk);
            tone_in = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset();
        // reset state (R3: count starts at zero, nothing detected)
        chk("R3", "reset tone_detect", tone_detect, 1'b0);
        chk("R6", "reset decode_n", decode_n, 1'b1);
        chk("R7", "reset rx_audio_en", rx_audio_en, 1'b0);

        for (int i = 0; i < NV; i++) begin
            tone_code       = VECS[i].code;
            rx_mode         = VECS[i].rx;
            listen_override = VECS[i].ptl;
            do_reset();
            pulses(int'(VECS[i].per), int'(VECS[i].edges));
            chk(vtag(i), $sformatf("vec %0d tone_detect", i), tone_detect, VECS[i].det);
            chk("R6", $sformatf("vec %0d decode_n", i), decode_n, ~VECS[i].det);
            chk("R7", $sformatf("vec %0d rx_audio_en", i), rx_audio_en, VECS[i].aud);
        end

        // R3/R4: saturate at 12, then 7 misses hold, the 8th releases
        tone_code = 6'd38; rx_mode = 1'b1; listen_override = 1'b0;
        do_reset();
        pulses(249, 20);
        chk("R4", "locked", tone_detect, 1'b1);
        pulses(300, 8);
        chk("R4", "hold above LO", tone_detect, 1'b1);
        pulses(300, 1);
        chk("R3", "release after clamp", tone_detect, 1'b0);
        chk("R6", "release decode_n", decode_n, 1'b1);

        // R5: idle input produces one miss per timeout
        do_reset();
        pulses(249, 20);
        repeat (7000) @(negedge clk);
        chk("R5", "after 7 timeouts", tone_detect, 1'b1);
        repeat (900) @(negedge clk);
        chk("R5", "after 8 timeouts", tone_detect, 1'b0);

        // R8: switching to transmit mutes and clears
        do_reset();
        pulses(249, 12);
        chk("R8", "locked before tx", tone_detect, 1'b1);
        rx_mode = 1'b0;
        @(negedge clk);
        chk("R8", "tx tone_detect", tone_detect, 1'b0);
        chk("R8", "tx rx_audio_en", rx_audio_en, 1'b0);
        @(negedge clk);
        rx_mode = 1'b1;
        @(negedge clk);
        chk("R8", "cleared on return", tone_detect, 1'b0);
        listen_override = 1'b1;
        @(negedge clk);
        chk("R7", "override after return", rx_audio_en, 1'b1);

        summary();
    end

endmodule